// File: doc/BRIEF.md
# Dual-Port Transparent Register File

This block is a small register file of four words. It has a write port and a read port, and each port has its own address, so a word can be written while the same word or another word is read. The write port captures the data word on the rising clock edge while its active-low enable is held low. A bypass path makes a read from the address being written show the incoming data in that same cycle. Seen from the read port, this behaves like transparent storage.

The read port is active-low. When it is disabled, the port stops driving its data and raises no drive flag. Several files can therefore share an external output bus, with the drive flag standing in for a high-impedance output. The word width is a parameter, so several instances on shared addresses build wider words. The storage array has no reset, so software must write a location before reading it.

Top module: `dprf_regfile`

## Requirements
- R1: When `wr_n` is low at a rising edge of `clk`, the word at address `wa` takes the value of `d` unchanged. It reads back in true (non-inverted) form from the next cycle on.
- R2: When `wr_n` is high at a rising edge, no stored word changes, whatever `d` and `wa` carry.
- R3: While `rd_n` is high, `q_oe` is 0 and `q` is all zeros, whatever the addresses and data.
- R4: While `rd_n` is low, `q_oe` is 1 and `q` shows the stored word at address `ra`. This is combinational, with no clock between them.
- R5: While `rd_n` and `wr_n` are both low and `ra` equals `wa`, `q` equals `d` in the same cycle (flow-through).
- R6: A write to one address and a read of a different address in the same cycle do not disturb each other. The read returns the old word at `ra`, and no word other than `wa` changes.
- R7: Reading is non-destructive: reading a word repeatedly returns the same value each time.
- R8: If `wa` changes while `wr_n` stays low over several edges, every address held at one of those edges is written with the data present at that edge. The address held at the last edge keeps the last data.
- R9: The word width is set by parameter `WIDTH` (default 4). A wider instance on the same addresses stores and returns every bit independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | Clock for the write port |
| wr_n | input  | 1 | Write enable, active low |
| wa   | input  | 2 | Write address |
| d    | input  | WIDTH | Write data |
| rd_n | input  | 1 | Read enable, active low |
| ra   | input  | 2 | Read address |
| q    | output | WIDTH | Read data, all zeros while not driving |
| q_oe | output | 1 | High while the read port drives `q` |

## Verification
A write and a read can fall in the same cycle, and this is the central concern. The bench provokes it by sweeping all sixteen pairs of write and read address with both enables low. When the addresses differ, `q` is judged against the bench's stored model (the old word). When they match, it is judged against `d` (the flow-through value). A follow-up read of every word then shows that only the written word moved. Seeded random cycles mix both enables and both addresses freely, and each cycle is judged by the same rule, on a 4-bit and an 8-bit instance.

// File: rtl/dprf_pkg.sv
package dprf_pkg;

    localparam int DPRF_DEF_WIDTH = 4;
    localparam int DPRF_DEF_DEPTH = 4;

    // Classification of a read in a given cycle
    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,
        RD_STORED = 2'd1,
        RD_BYPASS = 2'd2
    } rd_src_e;

    function automatic int unsigned clog2_min1(input int unsigned n);
        int unsigned r;
        r = 0;
        while ((1 << r) < n) r++;
        return (r == 0) ? 1 : r;
    endfunction

endpackage

// File: rtl/dprf_wr_decode.sv
module dprf_wr_decode #(
    parameter int DEPTH = 4,
    parameter int AW    = 2
) (
    input  logic             wr_n,
    input  logic [AW-1:0]    wa,
    output logic [DEPTH-1:0] we_vec
);

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_dec
        assign we_vec[gi] = !wr_n && (wa == AW'(gi));
    end

endmodule

// File: rtl/dprf_word.sv
module dprf_word #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             we,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] store_q;

    always_ff @(posedge clk) begin
        if (we) begin
            store_q <= d;
        end
    end

    assign q = store_q;

endmodule

// File: rtl/dprf_rd_port.sv
module dprf_rd_port
    import dprf_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int DEPTH = 4,
    parameter int AW    = 2
) (
    input  logic [DEPTH*WIDTH-1:0] words,
    input  logic [AW-1:0]          ra,
    input  logic                   rd_n,
    input  logic                   byp_hit,
    input  logic [WIDTH-1:0]       d,
    output logic [WIDTH-1:0]       q,
    output logic                   q_oe
);

    rd_src_e src;

    always_comb begin
        if (rd_n) begin
            src = RD_IDLE;
        end else if (byp_hit) begin
            src = RD_BYPASS;
        end else begin
            src = RD_STORED;
        end
    end

    always_comb begin
        q    = '0;
        q_oe = 1'b0;
        unique case (src)
            RD_IDLE: begin
                q    = '0;
                q_oe = 1'b0;
            end
            RD_BYPASS: begin
                q    = d;
                q_oe = 1'b1;
            end
            RD_STORED: begin
                q    = words[32'(ra)*WIDTH +: WIDTH];
                q_oe = 1'b1;
            end
            default: begin
                q    = '0;
                q_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dprf_regfile.sv
module dprf_regfile
    import dprf_pkg::*;
#(
    parameter int WIDTH = DPRF_DEF_WIDTH,
    parameter int DEPTH = DPRF_DEF_DEPTH,
    localparam int AW   = clog2_min1(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_n,
    input  logic [AW-1:0]    wa,
    input  logic [WIDTH-1:0] d,
    input  logic             rd_n,
    input  logic [AW-1:0]    ra,
    output logic [WIDTH-1:0] q,
    output logic             q_oe
);

    logic [DEPTH-1:0]       we_vec;
    logic [DEPTH*WIDTH-1:0] words;
    logic                   byp_hit;

    dprf_wr_decode #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_dec (
        .wr_n   (wr_n),
        .wa     (wa),
        .we_vec (we_vec)
    );

    for (genvar gw = 0; gw < DEPTH; gw++) begin : g_word
        dprf_word #(
            .WIDTH (WIDTH)
        ) u_word (
            .clk (clk),
            .we  (we_vec[gw]),
            .d   (d),
            .q   (words[gw*WIDTH +: WIDTH])
        );
    end

    assign byp_hit = !wr_n && (wa == ra);

    dprf_rd_port #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_rd (
        .words   (words),
        .ra      (ra),
        .rd_n    (rd_n),
        .byp_hit (byp_hit),
        .d       (d),
        .q       (q),
        .q_oe    (q_oe)
    );

endmodule

// File: rtl/dprf_regfile_chk.sv
module dprf_regfile_chk #(
    parameter int WIDTH = 4,
    parameter int AW    = 2
) (
    input logic             clk,
    input logic             wr_n,
    input logic [AW-1:0]    wa,
    input logic [WIDTH-1:0] d,
    input logic             rd_n,
    input logic [AW-1:0]    ra,
    input logic [WIDTH-1:0] q,
    input logic             q_oe
);

    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        armed <= 1'b1;
    end

    // R1
    write_lands_chk: assert property (@(posedge clk) disable iff (!armed)
        (wr_n && !rd_n && $past(!wr_n) && (ra == $past(wa))) |-> (q == $past(d)));

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!armed)
        (wr_n && !rd_n && $past(wr_n) && $past(!rd_n) && $stable(ra)) |-> $stable(q));

    // R3
    bus_released_chk: assert property (@(posedge clk) disable iff (!armed)
        rd_n |-> (!q_oe && (q == '0)));

    // R4
    bus_driven_chk: assert property (@(posedge clk) disable iff (!armed)
        !rd_n |-> q_oe);

    // R5
    flow_through_chk: assert property (@(posedge clk) disable iff (!armed)
        (!wr_n && !rd_n && (wa == ra)) |-> (q == d));

endmodule

bind dprf_regfile dprf_regfile_chk #(
    .WIDTH (WIDTH),
    .AW    (AW)
) u_chk (
    .clk  (clk),
    .wr_n (wr_n),
    .wa   (wa),
    .d    (d),
    .rd_n (rd_n),
    .ra   (ra),
    .q    (q),
    .q_oe (q_oe)
);

// File: tb/dprf_regfile_tb.sv
module dprf_regfile_tb;

    localparam int W  = 4;
    localparam int WW = 8;

    logic          clk = 1'b0;
    logic          wr_n, rd_n;
    logic [1:0]    wa, ra;
    logic [W-1:0]  d;
    logic [W-1:0]  q;
    logic          q_oe;
    logic [WW-1:0] qw;
    logic          qw_oe;

    logic [W-1:0]  model [4];
    int            tests = 0;
    int            fails = 0;
    bit            done  = 1'b0;

    always #4 clk = ~clk;

    dprf_regfile u_dut (
        .clk (clk), .wr_n (wr_n), .wa (wa), .d (d),
        .rd_n (rd_n), .ra (ra), .q (q), .q_oe (q_oe)
    );

    dprf_regfile #(.WIDTH(WW)) u_wide (
        .clk (clk), .wr_n (wr_n), .wa (wa), .d ({d, ~d}),
        .rd_n (rd_n), .ra (ra), .q (qw), .q_oe (qw_oe)
    );

    function automatic logic [W-1:0] exp_q(logic wn, logic [1:0] a_w,
                                           logic [W-1:0] dv, logic rn,
                                           logic [1:0] a_r);
        if (rn) return '0;
        if (!wn && a_w == a_r) return dv;
        return model[a_r];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one cycle, check combinational outputs, then commit the model
    task automatic step(string tag, logic wn, logic [1:0] a_w,
                        logic [W-1:0] dv, logic rn, logic [1:0] a_r);
        logic [W-1:0] e;
        @(negedge clk);
        wr_n = wn; wa = a_w; d = dv; rd_n = rn; ra = a_r;
        #1;
        e = exp_q(wn, a_w, dv, rn, a_r);
        chk({tag, " q"}, 32'(q), 32'(e));
        chk({tag, " q_oe"}, 32'(q_oe), 32'(!rn));
        chk("R9 wide q", 32'(qw), rn ? 32'd0 : 32'({e, ~e}));
        if (!wn) model[a_w] = dv;
    endtask

    task automatic read_all(string tag);
        for (int i = 0; i < 4; i++) step(tag, 1'b1, 2'(3 - i), 4'hF, 1'b0, 2'(i));
    endtask

    initial begin
        logic wn, rn;
        logic [1:0] aw, ar;
        logic [W-1:0] dv;
        string tag;
        void'($urandom(32'd20240611));
        wr_n = 1'b1; rd_n = 1'b1; wa = '0; ra = '0; d = '0;
        @(negedge clk); @(negedge clk);
        chk("R3 idle q_oe", 32'(q_oe), 32'd0);
        chk("R3 idle q", 32'(q), 32'd0);

        // R1: fill every word, then read back
        step("R1", 1'b0, 2'd0, 4'h5, 1'b1, 2'd0);
        step("R1", 1'b0, 2'd1, 4'hA, 1'b1, 2'd1);
        step("R1", 1'b0, 2'd2, 4'h3, 1'b1, 2'd2);
        step("R1", 1'b0, 2'd3, 4'hC, 1'b1, 2'd3);
        read_all("R1");
        // R7: read again
        read_all("R7");
        step("R7", 1'b1, 2'd0, 4'h0, 1'b0, 2'd2);
        step("R7", 1'b1, 2'd0, 4'h0, 1'b0, 2'd2);

        // R2: data and address toggle with the enable high
        for (int i = 0; i < 8; i++) step("R2", 1'b1, 2'(i), 4'(i * 7), 1'b0, 2'(i + 1));
        read_all("R2");

        // R3: bus released while a write happens
        step("R3", 1'b0, 2'd1, 4'h6, 1'b1, 2'd1);

        // R5 / R6: every write/read address pair in one cycle
        for (int w = 0; w < 4; w++) begin
            for (int r = 0; r < 4; r++) begin
                step((w == r) ? "R5" : "R6", 1'b0, 2'(w), 4'((w * 4 + r) ^ 9), 1'b0, 2'(r));
                read_all("R6");
            end
        end

        // R8: address moves during one long enable pulse
        step("R8", 1'b0, 2'd0, 4'h1, 1'b1, 2'd0);
        step("R8", 1'b0, 2'd1, 4'h2, 1'b1, 2'd0);
        step("R8", 1'b0, 2'd3, 4'h7, 1'b1, 2'd0);
        step("R8", 1'b0, 2'd3, 4'h8, 1'b1, 2'd0);
        read_all("R8");

        // seeded random mix
        for (int n = 0; n < 400; n++) begin
            wn = 1'($urandom());
            rn = ($urandom() % 4) == 0;
            aw = 2'($urandom());
            ar = ($urandom() % 3 == 0) ? aw : 2'($urandom());
            dv = 4'($urandom());
            if (rn) tag = "R3";
            else if (!wn && aw == ar) tag = "R5";
            else if (!wn) tag = "R6";
            else tag = "R4";
            step(tag, wn, aw, dv, rn, ar);
        end
        read_all("R4");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule